// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer of 9-bit words. The producer and the consumer each run on their own clock. Storage is a dual-port array whose depth is a parameter. Separate binary write and read pointers address it. Each pointer is also kept as a Gray-coded copy, which crosses into the other clock domain through a chain of synchronizing flops. Four active-low flags report occupancy. The write clock drives full and almost-full. The read clock drives empty and almost-empty.

A word is stored only when both write-side enables are active. A word is taken only when both read-side enables are active. Read data passes through an output register, and an output-enable input forces the data output to zero. The second write enable has two roles, chosen by its level while reset is held. If it is held high during reset, it remains a plain active-high enable. If it is held low during reset, it becomes an active-low load strobe. In that mode, write-clock edges with the strobe low fill the two offset registers in turn: first the almost-empty offset, then the almost-full offset. Read-clock edges with the strobe low present the offsets on the data output in the same alternating order.

A typical use is a rate-matching buffer between two clock domains. There, software or a sequencer tunes the early-warning thresholds once, just after reset.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While reset is held and right after it is released, the empty flag `empty_n` and the almost-empty flag `alm_empty_n` are low, and the full flag `full_n` and the almost-full flag `alm_full_n` are high.
- R2: Accepted words leave in the order they were written. The output register takes the new word on the read-clock edge that accepts the read.
- R3: A write stores a word only when `wr_en_n` is low and `wr_en2_ld` is high. A read takes a word only when both `rd_en1_n` and `rd_en2_n` are low. A single active enable changes neither the contents nor the data output.
- R4: `full_n` goes low once DEPTH words are held. A write attempted while `full_n` is low is dropped and leaves the contents unchanged.
- R5: `empty_n` is low when no words are held. A read attempted while `empty_n` is low leaves the data output at its previous value.
- R6: `alm_empty_n` is low when the number of held words is at most the almost-empty offset n, which includes the empty case.
- R7: `alm_full_n` is low when the number of held words is at least DEPTH minus the almost-full offset m. It returns high only on a write-clock edge, so it stays low while the write clock is stopped, even after reads.
- R8: If `wr_en2_ld` is low during reset, the block runs in load mode. In load mode, write-clock edges with `wr_en_n` low and `wr_en2_ld` low write `din` into the almost-empty offset and then the almost-full offset, alternating, and store nothing in the array.
- R9: In load mode, read-clock edges with both read enables low and `wr_en2_ld` low place the offsets on `dout`, zero-extended: almost-empty first, then almost-full, then almost-empty again.
- R10: While `oe_n` is high, `dout` is all zeros. While `oe_n` is low, `dout` shows the output register.
- R11: After reset, the offsets take the parameter values AE_INIT and AF_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high), or load strobe (active low) in load mode |
| din | input | DATA_W | Write data, or offset value in load mode |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable for `dout`, active low |
| dout | output | DATA_W | Read data, or offset readback |
| empty_n | output | 1 | Empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| alm_empty_n | output | 1 | Almost-empty flag, active low, read clock |
| alm_full_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
The hardest state to reach from the ports is an almost-full flag that should stay low even though reads have already made room. This happens because the flag is only re-evaluated on write-clock edges. The bench reaches it by filling the buffer to the almost-full threshold and then holding its own write clock low. While that clock is stopped, it performs reads and watches the flag for many read-clock cycles. Only then does it let the write clock run again and expect the flag to rise. Load mode is reached by holding the load strobe low through reset. After that, offset writes, readback order and the moved flag thresholds are all checked through the normal ports.

// File: rtl/dcff_pkg.sv
package dcff_pkg;

   // role of the second write enable, fixed while reset is held
   typedef enum logic {
      MODE_DATA = 1'b0,
      MODE_LOAD = 1'b1
   } ld_mode_e;

   // which offset register the next load or readback touches
   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;

endpackage

// File: rtl/dcff_ptr_sync.sv
module dcff_ptr_sync #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);

   logic [STAGES-1:0][PW-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], gray_in};
   end

   // Gray to binary: each bit is the parity of itself and all bits above it
   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign bin_out[i] = ^(stage_q[STAGES-1] >> i);
   end

endmodule

// File: rtl/dcff_wr_ctl.sv
module dcff_wr_ctl
   import dcff_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int AE_INIT = 7,
   parameter int AF_INIT = 7
) (
   input  logic              wclk,
   input  logic              mrst_n,
   input  logic              wr_en_n,
   input  logic              wr_en2_ld,
   input  logic [ADDR_W-1:0] ofs_din,
   input  logic [ADDR_W:0]   rbin_s,
   output ld_mode_e          ld_mode,
   output logic              mem_we,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wgray,
   output logic              full_n,
   output logic              alm_full_n,
   output logic [ADDR_W-1:0] ae_ofs,
   output logic [ADDR_W-1:0] af_ofs
);

   localparam int          PW     = ADDR_W + 1;
   localparam logic [PW:0] DEPTH_X = (PW+1)'(1) << ADDR_W;

   logic [PW-1:0] wbin_q, wbin_nx, wcnt_nx;
   logic          load_we, full_nx, almost_nx;
   ofs_sel_e      ld_sel;

   // the mode is sampled on every write-clock edge while reset is held
   always_ff @(posedge wclk) begin
      if (!mrst_n) ld_mode <= wr_en2_ld ? MODE_DATA : MODE_LOAD;
   end

   assign mem_we    = !wr_en_n && wr_en2_ld && full_n;
   assign load_we   = (ld_mode == MODE_LOAD) && !wr_en_n && !wr_en2_ld;
   assign waddr     = wbin_q[ADDR_W-1:0];
   assign wbin_nx   = wbin_q + PW'(mem_we);
   assign wcnt_nx   = wbin_nx - rbin_s;
   assign full_nx   = wcnt_nx[PW-1];
   assign almost_nx = ({1'b0, wcnt_nx} + {2'b0, af_ofs}) >= DEPTH_X;

   always_ff @(posedge wclk or negedge mrst_n) begin
      if (!mrst_n) begin
         wbin_q     <= '0;
         wgray      <= '0;
         full_n     <= 1'b1;
         alm_full_n <= 1'b1;
         ae_ofs     <= ADDR_W'(AE_INIT);
         af_ofs     <= ADDR_W'(AF_INIT);
         ld_sel     <= SEL_AE;
      end else begin
         wbin_q     <= wbin_nx;
         wgray      <= wbin_nx ^ (wbin_nx >> 1);
         full_n     <= !full_nx;
         alm_full_n <= !almost_nx;
         if (load_we) begin
            if (ld_sel == SEL_AE) ae_ofs <= ofs_din;
            else                  af_ofs <= ofs_din;
            ld_sel <= (ld_sel == SEL_AE) ? SEL_AF : SEL_AE;
         end
      end
   end

endmodule

// File: rtl/dcff_rd_ctl.sv
module dcff_rd_ctl
   import dcff_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 9
) (
   input  logic              rclk,
   input  logic              mrst_n,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   input  logic              rb_mode,
   input  logic [ADDR_W:0]   wbin_s,
   input  logic [ADDR_W-1:0] ae_ofs,
   input  logic [ADDR_W-1:0] af_ofs,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty_n,
   output logic              alm_empty_n,
   output logic [DATA_W-1:0] q
);

   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] rbin_q, rbin_nx, rcnt_nx;
   logic          rd_ok, mem_re, rb_re;
   ofs_sel_e      rb_sel;

   assign rd_ok   = !rd_en1_n && !rd_en2_n;
   assign mem_re  = rd_ok && !rb_mode && empty_n;
   assign rb_re   = rd_ok && rb_mode;
   assign raddr   = rbin_q[ADDR_W-1:0];
   assign rbin_nx = rbin_q + PW'(mem_re);
   assign rcnt_nx = wbin_s - rbin_nx;

   always_ff @(posedge rclk or negedge mrst_n) begin
      if (!mrst_n) begin
         rbin_q      <= '0;
         rgray       <= '0;
         empty_n     <= 1'b0;
         alm_empty_n <= 1'b0;
         q           <= '0;
         rb_sel      <= SEL_AE;
      end else begin
         rbin_q      <= rbin_nx;
         rgray       <= rbin_nx ^ (rbin_nx >> 1);
         empty_n     <= (rcnt_nx != '0);
         alm_empty_n <= (rcnt_nx > {1'b0, ae_ofs});
         if (mem_re) begin
            q <= mem_rdata;
         end else if (rb_re) begin
            q      <= DATA_W'((rb_sel == SEL_AE) ? ae_ofs : af_ofs);
            rb_sel <= (rb_sel == SEL_AE) ? SEL_AF : SEL_AE;
         end
      end
   end

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
   import dcff_pkg::*;
#(
   parameter int DATA_W      = 9,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int AE_INIT     = 7,
   parameter int AF_INIT     = 7
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst_n,
   input  logic              wr_en_n,
   input  logic              wr_en2_ld,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              full_n,
   output logic              alm_empty_n,
   output logic              alm_full_n
);

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PW     = ADDR_W + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("offsets must fit in one data word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AE_INIT >= DEPTH || AF_INIT >= DEPTH || AE_INIT < 0 || AF_INIT < 0) begin : g_bad_ofs
      $error("initial offsets must lie in 0 .. DEPTH-1");
   end

   ld_mode_e          ld_mode;
   logic              mem_we, rb_mode;
   logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
   logic [PW-1:0]     wgray, rgray, wbin_s, rbin_s;
   logic [DATA_W-1:0] mem_rdata, q;
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge wclk) begin
      if (mem_we) mem_q[waddr] <= din;
   end
   assign mem_rdata = mem_q[raddr];

   // the strobe level is used by the read side for readback; it is
   // expected to be steady while offsets are read back
   assign rb_mode = (ld_mode == MODE_LOAD) && !wr_en2_ld;

   dcff_wr_ctl #(.ADDR_W(ADDR_W), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)) u_wr (
      .wclk       (wclk),
      .mrst_n     (mrst_n),
      .wr_en_n    (wr_en_n),
      .wr_en2_ld  (wr_en2_ld),
      .ofs_din    (din[ADDR_W-1:0]),
      .rbin_s     (rbin_s),
      .ld_mode    (ld_mode),
      .mem_we     (mem_we),
      .waddr      (waddr),
      .wgray      (wgray),
      .full_n     (full_n),
      .alm_full_n (alm_full_n),
      .ae_ofs     (ae_ofs),
      .af_ofs     (af_ofs)
   );

   dcff_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .rclk        (rclk),
      .mrst_n      (mrst_n),
      .rd_en1_n    (rd_en1_n),
      .rd_en2_n    (rd_en2_n),
      .rb_mode     (rb_mode),
      .wbin_s      (wbin_s),
      .ae_ofs      (ae_ofs),
      .af_ofs      (af_ofs),
      .mem_rdata   (mem_rdata),
      .raddr       (raddr),
      .rgray       (rgray),
      .empty_n     (empty_n),
      .alm_empty_n (alm_empty_n),
      .q           (q)
   );

   dcff_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk     (rclk),
      .rst_n   (mrst_n),
      .gray_in (wgray),
      .bin_out (wbin_s)
   );

   dcff_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk     (wclk),
      .rst_n   (mrst_n),
      .gray_in (rgray),
      .bin_out (rbin_s)
   );

   assign dout = oe_n ? '0 : q;

endmodule

// File: rtl/dcff_checker.sv
module dcff_checker #(
   parameter int PW = 9
) (
   input logic          wclk,
   input logic          rclk,
   input logic          mrst_n,
   input logic          empty_n,
   input logic          full_n,
   input logic          alm_empty_n,
   input logic          alm_full_n,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray
);

   assert_reset_wflags_R1: assert property (@(posedge wclk) disable iff (!mrst_n)
      $rose(mrst_n) |-> (full_n && alm_full_n));

   assert_reset_rflags_R1: assert property (@(posedge rclk) disable iff (!mrst_n)
      $rose(mrst_n) |-> (!empty_n && !alm_empty_n));

   assert_wr_gray_step_R2: assert property (@(posedge wclk) disable iff (!mrst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   assert_rd_gray_step_R2: assert property (@(posedge rclk) disable iff (!mrst_n)
      $countones(rgray ^ $past(rgray)) <= 1);

   assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (!mrst_n)
      !full_n |=> $stable(wgray));

   assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!mrst_n)
      !empty_n |=> $stable(rgray));

   assert_empty_is_low_R6: assert property (@(posedge rclk) disable iff (!mrst_n)
      !empty_n |-> !alm_empty_n);

   assert_full_is_high_R7: assert property (@(posedge wclk) disable iff (!mrst_n)
      !full_n |-> !alm_full_n);

endmodule

bind dual_clock_flag_fifo dcff_checker #(.PW(PW)) u_chk (
   .wclk        (wclk),
   .rclk        (rclk),
   .mrst_n      (mrst_n),
   .empty_n     (empty_n),
   .full_n      (full_n),
   .alm_empty_n (alm_empty_n),
   .alm_full_n  (alm_full_n),
   .wgray       (wgray),
   .rgray       (rgray)
);

// File: tb/dual_clock_flag_fifo_test.sv
module dual_clock_flag_fifo_test;

   localparam int DW    = 9;
   localparam int DEPTH = 16;
   localparam int AE0   = 2;
   localparam int AF0   = 3;

   logic wclk = 1'b0, rclk = 1'b0, wclk_run = 1'b1;
   logic mrst_n = 1'b0, wr_en_n = 1'b1, wr_en2_ld = 1'b1;
   logic rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic empty_n, full_n, alm_empty_n, alm_full_n;

   always begin #5; if (wclk_run) wclk = ~wclk; end
   always #7 rclk = ~rclk;

   dual_clock_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2),
                          .AE_INIT(AE0), .AF_INIT(AF0)) uut (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
      .wr_en2_ld(wr_en2_ld), .din(din), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
      .oe_n(oe_n), .dout(dout), .empty_n(empty_n), .full_n(full_n),
      .alm_empty_n(alm_empty_n), .alm_full_n(alm_full_n));

   int errors = 0, checks = 0;
   int ae_n = AE0, af_m = AF0;
   bit done = 0, pend = 0;
   logic ld_level = 1'b1;
   logic [DW-1:0] pend_val;
   logic [DW-1:0] model[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic bit exp_alm_empty_n(int c);
      return c > ae_n;
   endfunction

   function automatic bit exp_alm_full_n(int c);
      return c < DEPTH - af_m;
   endfunction

   task automatic wr(input logic [DW-1:0] d, input bit e1, input bit e2);
      @(negedge wclk);
      din = d; wr_en_n = !e1; wr_en2_ld = e2;
      if (e1 && e2 && full_n) model.push_back(d);
   endtask

   task automatic wr_idle();
      @(negedge wclk);
      wr_en_n = 1'b1; wr_en2_ld = ld_level;
   endtask

   task automatic settle_check(input string req);
      if (pend) chk(dout === pend_val, req, "read data", dout, pend_val);
      pend = 0;
   endtask

   task automatic rd(input bit e1, input bit e2, input string req);
      @(negedge rclk);
      settle_check(req);
      rd_en1_n = !e1; rd_en2_n = !e2;
      pend = 1;
      if (e1 && e2 && empty_n) pend_val = model.pop_front();
      else                     pend_val = dout;
   endtask

   task automatic rd_idle(input string req);
      @(negedge rclk);
      settle_check(req);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
   endtask

   task automatic check_flags(input string tag);
      int c;
      repeat (8) @(negedge rclk);
      c = model.size();
      chk(empty_n == (c != 0), "R5", {tag, " empty flag"}, empty_n, c != 0);
      chk(full_n == (c != DEPTH), "R4", {tag, " full flag"}, full_n, c != DEPTH);
      chk(alm_empty_n == exp_alm_empty_n(c), "R6 R11", {tag, " almost-empty flag"},
          alm_empty_n, exp_alm_empty_n(c));
      chk(alm_full_n == exp_alm_full_n(c), "R7 R11", {tag, " almost-full flag"},
          alm_full_n, exp_alm_full_n(c));
   endtask

   task automatic do_reset(input bit load_mode);
      mrst_n = 1'b0; wr_en_n = 1'b1; ld_level = !load_mode; wr_en2_ld = ld_level;
      rd_en1_n = 1'b1; rd_en2_n = 1'b1; oe_n = 1'b0; pend = 0;
      model.delete();
      repeat (4) @(negedge wclk);
      #1 mrst_n = 1'b1;
      @(negedge rclk);
      chk(!empty_n, "R1", "empty after reset", empty_n, 0);
      chk(!alm_empty_n, "R1", "almost-empty after reset", alm_empty_n, 0);
      chk(full_n, "R1", "full after reset", full_n, 1);
      chk(alm_full_n, "R1", "almost-full after reset", alm_full_n, 1);
   endtask

   task automatic step_fill_drain(input string tag);
      check_flags({tag, " count 0"});
      for (int i = 0; i < DEPTH; i++) begin
         wr(DW'(i * 37 + 11), 1, 1);
         wr_idle();
         check_flags({tag, " filling"});
      end
      for (int i = 0; i < DEPTH; i++) begin
         rd(1, 1, "R2");
         rd_idle("R2");
         check_flags({tag, " draining"});
      end
   endtask

   initial begin
      #1_500_000;
      checks++; errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));

      // data mode, default offsets (R1, R11)
      do_reset(0);
      check_flags("defaults");
      for (int i = 0; i < DEPTH; i++) begin
         wr(DW'(i * 37 + 11), 1, 1);
         wr_idle();
         check_flags("fill R11");
      end

      // write while full is dropped (R4)
      wr(9'h1AA, 1, 1);
      wr_idle();
      check_flags("R4 write while full");
      for (int i = 0; i < DEPTH; i++) begin
         rd(1, 1, "R2 R4");
         rd_idle("R2 R4");
         check_flags("drain");
      end

      // read while empty holds the output (R5)
      rd(1, 1, "R5");
      rd_idle("R5");
      check_flags("R5 read while empty");

      // single enables are ignored, and data mode strobe low loads nothing (R3)
      wr(9'h055, 1, 0);
      wr(9'h066, 0, 1);
      wr_idle();
      check_flags("R3 gated write");
      chk(!empty_n, "R3", "gated write left buffer empty", empty_n, 0);
      wr(9'h177, 1, 1);
      wr_idle();
      check_flags("one word");
      rd(1, 0, "R3");
      rd(0, 1, "R3");
      rd_idle("R3");
      check_flags("R3 gated read");
      rd(1, 1, "R2");
      rd_idle("R2");

      // output enable (R10)
      @(negedge rclk);
      oe_n = 1'b1;
      #1 chk(dout == '0, "R10", "dout with oe_n high", dout, 0);
      oe_n = 1'b0;
      #1 chk(dout == 9'h177, "R10", "dout with oe_n low", dout, 9'h177);

      // almost-full released only by the write clock (R7)
      for (int i = 0; i < DEPTH - af_m; i++) begin
         wr(DW'(i + 100), 1, 1);
      end
      wr_idle();
      check_flags("R7 at threshold");
      @(negedge wclk);
      wclk_run = 1'b0;
      rd(1, 1, "R2");
      rd(1, 1, "R2");
      rd_idle("R2");
      repeat (12) @(negedge rclk);
      chk(!alm_full_n, "R7", "almost-full held while write clock stopped", alm_full_n, 0);
      wclk_run = 1'b1;
      check_flags("R7 write clock resumed");
      while (model.size() > 0) rd(1, 1, "R2");
      rd_idle("R2");
      check_flags("emptied");

      // constrained random traffic (R2, R3, R4, R5)
      fork
         begin
            for (int i = 0; i < 500; i++)
               wr(DW'($urandom), ($urandom % 100) < 85, ($urandom % 100) < 92);
            wr_idle();
         end
         begin
            for (int i = 0; i < 500; i++)
               rd(($urandom % 100) < ((i < 250) ? 45 : 90),
                  ($urandom % 100) < 92, "R2 R3");
            rd_idle("R2");
         end
      join
      check_flags("after random");
      while (model.size() > 0) rd(1, 1, "R2");
      rd_idle("R2");
      check_flags("random drained");

      // load mode: offsets written in order, read back in order (R8, R9)
      do_reset(1);
      wr(9'd5, 1, 0);
      wr(9'd4, 1, 0);
      wr_idle();
      check_flags("R8 loads stored no word");
      @(negedge rclk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      @(negedge rclk);
      chk(dout == 9'd5, "R9", "first readback (almost-empty)", dout, 5);
      @(negedge rclk);
      chk(dout == 9'd4, "R9", "second readback (almost-full)", dout, 4);
      @(negedge rclk);
      chk(dout == 9'd5, "R9", "third readback wraps", dout, 5);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      ae_n = 5; af_m = 4; ld_level = 1'b1;
      wr_idle();
      step_fill_drain("R8 loaded offsets");

      finish_run();
   end

endmodule